// File: doc/BRIEF.md
# Quadratic Raster Evaluator with Ping-Pong Coefficient Banks

The block produces the value of a two-variable quadratic, F(x,y) = A·x² + B·y² + C·x·y + D·x + E·y + F, at successive pixels of a raster. It uses no multiplier. Each value comes from running sums: a line-level set of accumulators steps the y-dependent terms, and a pixel-level set steps the x-dependent terms. Both levels use second-order differences, so every step costs only additions. All arithmetic is 48 bits wide, modulo 2^48. Each 48-bit addition is split into a low 24-bit half and a high 24-bit half, one clock apart, with the carry registered between them. An output register pairs the two halves again.

Two banks of six coefficient words are kept. The host always writes the bank that is not driving the computation. A patch-done pulse exchanges the roles of the two banks and restarts the raster at line zero. The raster controller issues a line-start strobe before each line and one pixel-step strobe per pixel. Each pixel-step returns the value at the current position.

Top module: `qfd_eval`

## Requirements
- R1: After synchronous reset, `value_valid` is 0, `value_out` is 0, bank 0 is active and both banks hold zeros, so any raster evaluated before the first swap yields 0.
- R2: A host write stores `cfg_wr_data` into word `cfg_wr_addr` of the inactive bank. The word addresses are 0 = x² coefficient, 1 = y² coefficient, 2 = x·y coefficient, 3 = x coefficient, 4 = y coefficient, 5 = constant. A write to address 6 or 7 changes nothing.
- R3: The active bank changes only on `patch_done`, which exchanges the two banks. Host writes never alter the contents of the active bank, so values in progress are unaffected.
- R4: The first `line_start` after a swap selects line y = 0, and each further `line_start` selects the next y. Every `line_start` sets x back to 0.
- R5: Each `pixel_step` returns F(x,y) for the current x and y, computed from the active bank, and then advances x by one. Consecutive-cycle steps are supported.
- R6: `value_valid` is high for exactly one cycle per accepted pixel step. It appears in the second cycle after the cycle in which the strobe is sampled.
- R7: Results are exact modulo 2^48, including carries across the boundary between the two 24-bit halves and negative coefficients in two's complement.
- R8: When strobes coincide, `patch_done` takes precedence over `line_start`, and `line_start` takes precedence over `pixel_step`. The lower-priority strobe in that cycle has no effect and, for a pixel step, produces no valid output.
- R9: `value_out` keeps its last value while `value_valid` is low.
- R10: A host write in the same cycle as `patch_done` lands in the bank that becomes inactive at that edge, that is, the previously active bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Host coefficient write enable |
| cfg_wr_addr | input | 3 | Coefficient word address |
| cfg_wr_data | input | 48 | Coefficient word, two's complement |
| patch_done | input | 1 | Swap banks and restart the raster at line 0 |
| line_start | input | 1 | Begin the next raster line |
| pixel_step | input | 1 | Evaluate the current pixel and advance x |
| value_valid | output | 1 | `value_out` carries a new pixel result |
| value_out | output | 48 | F(x,y) modulo 2^48 |

## Verification
On every cycle, the assertions check the following:
- the two-cycle valid timing of R6;
- the absence of valid pulses for suppressed strobes;
- that the output holds while valid is low;
- that the bank select moves only on `patch_done`;
- that the active coefficients stay frozen under host writes.

Only the bench scenarios can show that the value is numerically right. These scenarios are raster sweeps over several coefficient sets, compared against F(x,y) computed directly. They also cover the line and pixel ordering after a swap, the routing of a write that coincides with a swap, and carries between the 24-bit halves.

// File: rtl/qfd_pkg.sv
package qfd_pkg;

    localparam int WORD_W    = 48;
    localparam int HALF_W    = WORD_W / 2;
    localparam int NUM_COEF  = 6;
    localparam int ADDR_W    = $clog2(NUM_COEF + 1);
    localparam int NUM_BANKS = 2;

    // coefficient word addresses
    localparam int IDX_XX = 0;
    localparam int IDX_YY = 1;
    localparam int IDX_XY = 2;
    localparam int IDX_X  = 3;
    localparam int IDX_Y  = 4;
    localparam int IDX_K  = 5;

    // accumulator slots
    localparam int ACC_V   = 0;  // pixel value
    localparam int ACC_S   = 1;  // pixel first difference
    localparam int ACC_Q   = 2;  // next line start value
    localparam int ACC_R   = 3;  // next line increment
    localparam int ACC_N   = 4;  // next line pixel first difference
    localparam int NUM_ACC = 5;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [NUM_COEF-1:0][WORD_W-1:0] bank_t;

    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_LOAD = 2'd1,
        ACC_ADD  = 2'd2
    } acc_op_e;

    typedef struct packed {
        word_t q_init;  // Q(0)
        word_t r_init;  // Q(1)-Q(0)
        word_t n_init;  // F(1,0)-F(0,0)
        word_t d_a;     // second x difference
        word_t d_b;     // second y difference
        word_t d_c;     // step of pixel difference per line
    } seed_t;

    function automatic seed_t derive_seed(bank_t bk);
        seed_t s;
        s.q_init = bk[IDX_K];
        s.r_init = bk[IDX_YY] + bk[IDX_Y];
        s.n_init = bk[IDX_XX] + bk[IDX_X];
        s.d_a    = bk[IDX_XX] << 1;
        s.d_b    = bk[IDX_YY] << 1;
        s.d_c    = bk[IDX_XY];
        return s;
    endfunction

    function automatic half_t lo_of(word_t w);
        return w[HALF_W-1:0];
    endfunction

    function automatic half_t hi_of(word_t w);
        return w[WORD_W-1:HALF_W];
    endfunction

endpackage

// File: rtl/qfd_coef_banks.sv
module qfd_coef_banks
    import qfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_data,
    input  logic              swap,
    output logic              act_sel,
    output bank_t             act_bank,
    output bank_t             inc_bank
);

    bank_t mem_q [NUM_BANKS];
    logic  sel_q;
    logic  tgt;
    logic  addr_ok;

    // target is whichever bank is inactive after this edge
    assign tgt     = swap ? sel_q : ~sel_q;
    assign addr_ok = wr_addr < ADDR_W'(NUM_COEF);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                mem_q[b] <= '0;
            end
        end else begin
            if (swap) begin
                sel_q <= ~sel_q;
            end
            if (wr_en && addr_ok) begin
                mem_q[tgt][wr_addr] <= wr_data;
            end
        end
    end

    assign act_sel  = sel_q;
    assign act_bank = mem_q[sel_q];
    assign inc_bank = mem_q[~sel_q];

endmodule

// File: rtl/qfd_split_acc.sv
module qfd_split_acc
    import qfd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  acc_op_e op,
    input  half_t   ld_lo,
    input  half_t   inc_lo,
    input  half_t   ld_hi,
    input  half_t   inc_hi,
    output half_t   lo_q,
    output half_t   hi_q
);

    acc_op_e op_d;
    logic    cy_q;

    // low half acts on the current op
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            cy_q <= 1'b0;
            op_d <= ACC_HOLD;
        end else begin
            op_d <= op;
            case (op)
                ACC_LOAD: begin
                    lo_q <= ld_lo;
                    cy_q <= 1'b0;
                end
                ACC_ADD: begin
                    {cy_q, lo_q} <= {1'b0, lo_q} + {1'b0, inc_lo};
                end
                default: cy_q <= 1'b0;
            endcase
        end
    end

    // high half replays the same op one cycle later with the carry
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
        end else begin
            case (op_d)
                ACC_LOAD: hi_q <= ld_hi;
                ACC_ADD:  hi_q <= hi_q + inc_hi + HALF_W'(cy_q);
                default:  hi_q <= hi_q;
            endcase
        end
    end

endmodule

// File: rtl/qfd_eval.sv
module qfd_eval
    import qfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_wr_addr,
    input  logic [WORD_W-1:0] cfg_wr_data,
    input  logic              patch_done,
    input  logic              line_start,
    input  logic              pixel_step,
    output logic              value_valid,
    output logic [WORD_W-1:0] value_out
);

    logic    act_sel;
    bank_t   act_bank;
    bank_t   inc_bank;
    seed_t   seed_act;
    seed_t   seed_inc;
    logic    go_swap, go_line, go_pix;

    acc_op_e op     [NUM_ACC];
    half_t   ld_lo  [NUM_ACC];
    half_t   inc_lo [NUM_ACC];
    half_t   ld_hi  [NUM_ACC];
    half_t   inc_hi [NUM_ACC];
    half_t   lo_q   [NUM_ACC];
    half_t   hi_q   [NUM_ACC];

    logic    pix_d;
    half_t   cap_lo;

    qfd_coef_banks u_banks (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .wr_addr  (cfg_wr_addr),
        .wr_data  (cfg_wr_data),
        .swap     (patch_done),
        .act_sel  (act_sel),
        .act_bank (act_bank),
        .inc_bank (inc_bank)
    );

    assign seed_act = derive_seed(act_bank);
    assign seed_inc = derive_seed(inc_bank);

    // strobe priority: swap > line > pixel
    assign go_swap = patch_done;
    assign go_line = line_start & ~patch_done;
    assign go_pix  = pixel_step & ~line_start & ~patch_done;

    always_comb begin
        // operands for the low half (current cycle)
        ld_lo[ACC_V]  = lo_q[ACC_Q];
        ld_lo[ACC_S]  = lo_q[ACC_N];
        ld_lo[ACC_Q]  = lo_of(seed_inc.q_init);
        ld_lo[ACC_R]  = lo_of(seed_inc.r_init);
        ld_lo[ACC_N]  = lo_of(seed_inc.n_init);
        inc_lo[ACC_V] = lo_q[ACC_S];
        inc_lo[ACC_S] = lo_of(seed_act.d_a);
        inc_lo[ACC_Q] = lo_q[ACC_R];
        inc_lo[ACC_R] = lo_of(seed_act.d_b);
        inc_lo[ACC_N] = lo_of(seed_act.d_c);
        // operands for the high half (one cycle behind)
        ld_hi[ACC_V]  = hi_q[ACC_Q];
        ld_hi[ACC_S]  = hi_q[ACC_N];
        ld_hi[ACC_Q]  = hi_of(seed_act.q_init);
        ld_hi[ACC_R]  = hi_of(seed_act.r_init);
        ld_hi[ACC_N]  = hi_of(seed_act.n_init);
        inc_hi[ACC_V] = hi_q[ACC_S];
        inc_hi[ACC_S] = hi_of(seed_act.d_a);
        inc_hi[ACC_Q] = hi_q[ACC_R];
        inc_hi[ACC_R] = hi_of(seed_act.d_b);
        inc_hi[ACC_N] = hi_of(seed_act.d_c);

        for (int i = 0; i < NUM_ACC; i++) begin
            op[i] = ACC_HOLD;
        end
        if (go_swap) begin
            op[ACC_Q] = ACC_LOAD;
            op[ACC_R] = ACC_LOAD;
            op[ACC_N] = ACC_LOAD;
        end else if (go_line) begin
            op[ACC_V] = ACC_LOAD;
            op[ACC_S] = ACC_LOAD;
            op[ACC_Q] = ACC_ADD;
            op[ACC_R] = ACC_ADD;
            op[ACC_N] = ACC_ADD;
        end else if (go_pix) begin
            op[ACC_V] = ACC_ADD;
            op[ACC_S] = ACC_ADD;
        end
    end

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
        qfd_split_acc u_acc (
            .clk    (clk),
            .rst    (rst),
            .op     (op[g]),
            .ld_lo  (ld_lo[g]),
            .inc_lo (inc_lo[g]),
            .ld_hi  (ld_hi[g]),
            .inc_hi (inc_hi[g]),
            .lo_q   (lo_q[g]),
            .hi_q   (hi_q[g])
        );
    end

    // low half captured at the strobe, high half one cycle later
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_d       <= 1'b0;
            cap_lo      <= '0;
            value_valid <= 1'b0;
            value_out   <= '0;
        end else begin
            pix_d <= go_pix;
            if (go_pix) begin
                cap_lo <= lo_q[ACC_V];
            end
            value_valid <= pix_d;
            if (pix_d) begin
                value_out <= {hi_q[ACC_V], cap_lo};
            end
        end
    end

endmodule

// File: rtl/qfd_eval_checker.sv
module qfd_eval_checker
    import qfd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              patch_done,
    input logic              line_start,
    input logic              pixel_step,
    input logic              value_valid,
    input logic [WORD_W-1:0] value_out,
    input logic              act_sel,
    input bank_t             act_bank
);

    logic accepted;
    assign accepted = pixel_step && !line_start && !patch_done;

    assert_valid_latency_R6: assert property (@(posedge clk) disable iff (rst)
        accepted |=> ##1 value_valid);

    // suppressed or absent strobes give no output pulse
    assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (rst)
        !accepted |=> ##1 !value_valid);

    assert_output_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !value_valid |-> $stable(value_out));

    assert_sel_steady_R3: assert property (@(posedge clk) disable iff (rst)
        !patch_done |=> $stable(act_sel));

    assert_sel_flips_R3: assert property (@(posedge clk) disable iff (rst)
        patch_done |=> (act_sel != $past(act_sel)));

    // host writes never reach the active bank
    assert_active_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        !patch_done |=> $stable(act_bank));

endmodule

bind qfd_eval qfd_eval_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .patch_done  (patch_done),
    .line_start  (line_start),
    .pixel_step  (pixel_step),
    .value_valid (value_valid),
    .value_out   (value_out),
    .act_sel     (act_sel),
    .act_bank    (act_bank)
);

// File: tb/qfd_eval_test.sv
`timescale 1ns/1ps
module qfd_eval_test;
    import qfd_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_wr_en = 1'b0;
    logic [ADDR_W-1:0] cfg_wr_addr = '0;
    logic [WORD_W-1:0] cfg_wr_data = '0;
    logic              patch_done = 1'b0;
    logic              line_start = 1'b0;
    logic              pixel_step = 1'b0;
    logic              value_valid;
    logic [WORD_W-1:0] value_out;

    int checks = 0;
    int errors = 0;

    longint bank_m [2][6];
    int     act_m = 0;
    longint next_y = 0;
    longint cur_y = 0;
    longint cur_x = 0;

    always #2.5 clk = ~clk;

    qfd_eval uut (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_addr (cfg_wr_addr),
        .cfg_wr_data (cfg_wr_data),
        .patch_done  (patch_done),
        .line_start  (line_start),
        .pixel_step  (pixel_step),
        .value_valid (value_valid),
        .value_out   (value_out)
    );

    function automatic logic [47:0] fval(int b, longint x, longint y);
        longint r;
        r = bank_m[b][0]*x*x + bank_m[b][1]*y*y + bank_m[b][2]*x*y
          + bank_m[b][3]*x + bank_m[b][4]*y + bank_m[b][5];
        return r[47:0];
    endfunction

    task automatic check(bit ok, string req, logic [47:0] act, logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (x=%0d y=%0d)", req, act, exp, cur_x, cur_y);
        end
    endtask

    task automatic wr(int addr, longint data);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_addr = ADDR_W'(addr);
        cfg_wr_data = data[47:0];
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (addr < 6) bank_m[1-act_m][addr] = data;
    endtask

    task automatic load_set(longint a, longint b, longint c, longint d, longint e, longint f);
        wr(0, a); wr(1, b); wr(2, c); wr(3, d); wr(4, e); wr(5, f);
    endtask

    task automatic swap();
        @(negedge clk);
        patch_done = 1'b1;
        @(negedge clk);
        patch_done = 1'b0;
        act_m  = 1 - act_m;
        next_y = 0;
    endtask

    task automatic new_line();
        @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        cur_y = next_y;
        next_y++;
        cur_x = 0;
    endtask

    // back-to-back pixel burst, each result checked two cycles later
    task automatic run_pixels(int n, string req);
        longint x0 = cur_x;
        for (int i = 0; i < n + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                logic [47:0] e;
                e = fval(act_m, x0 + i - 2, cur_y);
                check(value_valid === 1'b1 && value_out === e, req, value_out, e);
            end
            pixel_step = (i < n);
        end
        pixel_step = 1'b0;
        cur_x = x0 + n;
        @(negedge clk);
        check(value_valid === 1'b0, "R6", {47'd0, value_valid}, 48'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int k = 0; k < 6; k++) bank_m[b][k] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state and zero banks
        check(value_valid === 1'b0, "R1", {47'd0, value_valid}, 48'd0);
        check(value_out === 48'd0, "R1", value_out, 48'd0);
        new_line();
        run_pixels(3, "R1");

        // R2: load bank 1, junk to address 6 and 7 ignored
        load_set(3, -2, 5, -7, 11, 100);
        wr(6, 64'h0000_1234_5678_9ABC);
        wr(7, -1);
        swap();
        // R4/R5: raster sweep
        for (int y = 0; y < 6; y++) begin
            new_line();
            run_pixels(7, "R5");
        end
        // R4: restart at line 0 after swap back to same content via reload
        load_set(-4, 9, -3, 2, -6, -50);
        // R3: inactive writes leave ongoing raster unchanged
        new_line();
        run_pixels(3, "R3");
        wr(0, 999);
        bank_m[1-act_m][0] = 999;
        run_pixels(3, "R3");
        wr(0, -4);
        swap();
        for (int y = 0; y < 3; y++) begin
            new_line();
            run_pixels(5, "R4");
        end

        // R7: large coefficients, carries across halves, wraparound
        load_set(64'sh3F_FFFF, -64'sh1_2345_6789, 64'sh7F_FFFF, -1, 64'shFF_FFFF, 64'shFF_FFFF_FFF0);
        swap();
        for (int y = 0; y < 4; y++) begin
            new_line();
            run_pixels(40, "R7");
        end

        // R6/R9: isolated steps, exact timing and hold
        new_line();
        for (int k = 0; k < 4; k++) begin
            logic [47:0] e;
            e = fval(act_m, cur_x, cur_y);
            @(negedge clk);
            pixel_step = 1'b1;
            @(negedge clk);
            pixel_step = 1'b0;
            check(value_valid === 1'b0, "R6", {47'd0, value_valid}, 48'd0);
            @(negedge clk);
            check(value_valid === 1'b1 && value_out === e, "R6", value_out, e);
            @(negedge clk);
            check(value_valid === 1'b0 && value_out === e, "R9", value_out, e);
            repeat (3) @(negedge clk);
            check(value_out === e, "R9", value_out, e);
            cur_x++;
        end

        // R8: line + pixel together -> pixel dropped, line taken
        @(negedge clk);
        line_start = 1'b1; pixel_step = 1'b1;
        @(negedge clk);
        line_start = 1'b0; pixel_step = 1'b0;
        cur_y = next_y; next_y++; cur_x = 0;
        @(negedge clk);
        check(value_valid === 1'b0, "R8", {47'd0, value_valid}, 48'd0);
        run_pixels(4, "R8");

        // R8: swap + line -> line dropped, next line is y=0 of new bank
        load_set(7, 1, -2, 3, 4, -9);
        @(negedge clk);
        patch_done = 1'b1; line_start = 1'b1;
        @(negedge clk);
        patch_done = 1'b0; line_start = 1'b0;
        act_m = 1 - act_m; next_y = 0;
        new_line();
        check(cur_y == 0, "R8", cur_y[47:0], 48'd0);
        run_pixels(4, "R8");

        // R8: swap + pixel -> no output
        @(negedge clk);
        patch_done = 1'b1; pixel_step = 1'b1;
        @(negedge clk);
        patch_done = 1'b0; pixel_step = 1'b0;
        act_m = 1 - act_m; next_y = 0;
        @(negedge clk);
        check(value_valid === 1'b0, "R8", {47'd0, value_valid}, 48'd0);
        new_line();
        run_pixels(3, "R8");

        // R10: write during swap lands in previously active bank
        @(negedge clk);
        patch_done = 1'b1; cfg_wr_en = 1'b1;
        cfg_wr_addr = 3'd5; cfg_wr_data = 48'd777;
        @(negedge clk);
        patch_done = 1'b0; cfg_wr_en = 1'b0;
        bank_m[act_m][5] = 777;
        act_m = 1 - act_m; next_y = 0;
        new_line();
        run_pixels(3, "R10");
        swap();
        new_line();
        new_line();
        run_pixels(3, "R10");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule